// File: doc/BRIEF.md
# Pipelined 40-bit SPI register slave

This block lets an external SPI master read and write an internal register bank. The master sends 40-bit frames, most significant bit first. Each frame holds a command byte and a 32-bit data word. The top bit of the command byte marks a write, and the low seven bits give the register address. While the master shifts a command in, the block shifts a reply out. The reply starts with an 8-bit status vector and ends with a 32-bit word. That word is the result of the read requested in the previous frame, so a run of reads pipelines with one frame of latency.

All serial inputs are synchronized into the system clock, and their edges are found in that domain. A command takes effect only when chip select rises, and only if at least 40 SCK rising edges were seen. If more than 40 bits are clocked, the extra bits pass through the 40-bit shift register to MISO, which allows daisy chaining. The last 40 bits received form the command. The register bank sees a one-cycle write or read strobe. Read data is taken from the bank on the cycle the read strobe is high.

Top module: `spi40_reg_slave`

## Requirements
- R1: In every frame the first 8 bits on MISO are the status input, sampled when CS falls, MSB first. The 32 reply bits follow. MISO changes only after a falling SCK edge or a CS fall.
- R2: A full frame whose first bit is 1 produces exactly one one-cycle write strobe after CS rises. `reg_addr_o` carries the next 7 bits, and `reg_wdata_o` carries the final 32 bits.
- R3: A full frame whose first bit is 0 produces exactly one one-cycle read strobe with the 7-bit address. Its data field is ignored, and `reg_wdata_o` keeps its value.
- R4: After a read frame, the next frame's reply word equals `reg_rdata_i`, captured in the cycle the read strobe was high. This holds whether the next frame is a read or a write.
- R5: After a write frame, the next frame's reply word is the data just written.
- R6: After reset, MISO is 0, both strobes are low, and the first reply word is all zeros.
- R7: A frame with fewer than 40 SCK rising edges gives no strobe and leaves the next reply word unchanged. An 8-bit frame still returns the status byte.
- R8: In a frame longer than 40 bits, MOSI bits reappear on MISO 40 bits later. The command is taken from the last 40 bits. The bit counter saturates and does not wrap.
- R9: The write and read strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x SCK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI clock, idles high |
| mosi_i | input | 1 | Serial data from master |
| cs_ni | input | 1 | Active-low chip select |
| miso_o | output | 1 | Serial data to master |
| status_i | input | 8 | Status vector sent first in each frame |
| reg_addr_o | output | 7 | Register address |
| reg_wdata_o | output | 32 | Register write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 32 | Register read data, sampled while reg_re_o is high |

## Verification
The hardest state to reach from the ports is an overlong frame. In that frame the shift register has to give up its reply contents and pass earlier MOSI bits through. At the same time the command decode must ignore the leading bits. The bench builds this with a 48-bit frame: an 8-bit marker prefix, then a read command. It checks that the marker appears in bits 41 to 48 of MISO and that only the trailing read produces a strobe. Truncated frames of 8 and 39 bits are placed between full frames. This shows that the pipelined reply carries across them unchanged.

// File: rtl/spi40_pkg.sv
package spi40_pkg;
  localparam int unsigned FRAME_W = 40;
  localparam int unsigned CMD_W   = 8;
  localparam int unsigned DATA_W  = FRAME_W - CMD_W;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned ADDR_W  = CMD_W - 1;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/spi40_sync.sv
module spi40_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/spi40_framer.sv
module spi40_framer
  import spi40_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               mosi_i,
  input  logic               cs_ni,
  input  logic [STAT_W-1:0]  status_i,
  input  logic [DATA_W-1:0]  reply_i,
  output logic               miso_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               cs_rise_o,
  output logic               frame_ok_o,
  output logic [CNT_W-1:0]   bit_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic sck_d, cs_d;
  logic sck_rise, sck_fall, cs_fall;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               miso_q;

  assign sck_rise  = sck_i & ~sck_d;
  assign sck_fall  = ~sck_i & sck_d;
  assign cs_fall   = ~cs_ni & cs_d;
  assign cs_rise_o = cs_ni & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d <= 1'b1;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_i;
      cs_d  <= cs_ni;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      miso_q  <= 1'b0;
    end else if (cs_fall) begin
      // reply is preloaded so the status MSB is on the line before the first edge
      shreg_q <= {status_i, reply_i};
      cnt_q   <= '0;
      miso_q  <= status_i[STAT_W-1];
    end else if (!cs_ni) begin
      if (sck_rise) begin
        shreg_q <= {shreg_q[FRAME_W-2:0], mosi_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (sck_fall) miso_q <= shreg_q[FRAME_W-1];
    end
  end

  assign miso_o     = miso_q;
  assign frame_o    = shreg_q;
  assign frame_ok_o = (cnt_q >= CNT_FULL);
  assign bit_cnt_o  = cnt_q;

  p_miso_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_fall && !cs_fall) |=> $stable(miso_q));
  p_cnt_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !cs_fall) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/spi40_cmd.sv
module spi40_cmd
  import spi40_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_rise_i,
  input  logic               frame_ok_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic               we_o,
  output logic               re_o,
  output logic [DATA_W-1:0]  reply_o
);
  cmd_t cmd;
  assign cmd = cmd_t'(frame_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      we_o    <= 1'b0;
      re_o    <= 1'b0;
      reply_o <= '0;
    end else begin
      we_o <= 1'b0;
      re_o <= 1'b0;
      if (re_o) reply_o <= rdata_i;
      if (cs_rise_i && frame_ok_i) begin
        addr_o <= cmd.addr;
        if (cmd.wr) begin
          we_o    <= 1'b1;
          wdata_o <= cmd.data;
          reply_o <= cmd.data;
        end else begin
          re_o <= 1'b1;
        end
      end
    end
  end

  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && re_o));
  p_we_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  p_re_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |=> !re_o);
endmodule

// File: rtl/spi40_reg_slave.sv
module spi40_reg_slave
  import spi40_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              cs_ni,
  output logic              miso_o,
  input  logic [STAT_W-1:0] status_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic [2:0]         sync_q;
  logic [FRAME_W-1:0] frame;
  logic               cs_rise, frame_ok;
  logic [CNT_W-1:0]   bit_cnt;
  logic [DATA_W-1:0]  reply;

  spi40_sync #(.WIDTH(3), .RST_VAL(3'b101)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sck_i, mosi_i, cs_ni}),
    .q_o    (sync_q)
  );

  spi40_framer u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sync_q[2]),
    .mosi_i     (sync_q[1]),
    .cs_ni      (sync_q[0]),
    .status_i   (status_i),
    .reply_i    (reply),
    .miso_o     (miso_o),
    .frame_o    (frame),
    .cs_rise_o  (cs_rise),
    .frame_ok_o (frame_ok),
    .bit_cnt_o  (bit_cnt)
  );

  spi40_cmd u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_rise_i  (cs_rise),
    .frame_ok_i (frame_ok),
    .frame_i    (frame),
    .rdata_i    (reg_rdata_i),
    .addr_o     (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o),
    .re_o       (reg_re_o),
    .reply_o    (reply)
  );

  p_full_frame_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |-> $past(bit_cnt) >= CNT_W'(FRAME_W));
endmodule

// File: tb/tb_spi40_reg_slave.sv
module tb_spi40_reg_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1, mosi = 1'b0, cs_n = 1'b1;
  logic miso;
  logic [7:0] status = '0;
  logic [6:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic reg_we, reg_re;

  int errors = 0, checks = 0;
  int we_seen = 0, re_seen = 0, both_seen = 0;
  logic [6:0] we_addr, re_addr;
  logic [31:0] we_data;
  logic [31:0] model_reply = '0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] bank(logic [6:0] a);
    return {a, ~a, 18'h2B6C3};
  endfunction
  assign reg_rdata = bank(reg_addr);

  spi40_reg_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .cs_ni(cs_n),
    .miso_o(miso), .status_i(status), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_re_o(reg_re),
    .reg_rdata_i(reg_rdata)
  );

  // strobe monitor, sampled every clock away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin we_seen++; we_addr = reg_addr; we_data = reg_wdata; end
      if (reg_re) begin re_seen++; re_addr = reg_addr; end
      if (reg_we && reg_re) both_seen++;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    we_seen = 0; re_seen = 0; both_seen = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (6) @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sck = 1'b0; mosi = din[n-1-i];
      repeat (5) @(posedge clk);
      @(negedge clk); dout[n-1-i] = miso; sck = 1'b1;
      repeat (5) @(posedge clk);
    end
    @(negedge clk) cs_n = 1'b1;
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic full_frame(string tag, logic [7:0] st, logic [39:0] cmd);
    logic [63:0] d;
    status = st;
    xfer(40, {24'h0, cmd}, d);
    chk({tag, " R1 status"}, {56'h0, d[39:32]}, {56'h0, st});
    chk({tag, " R4/R5 reply"}, {32'h0, d[31:0]}, {32'h0, model_reply});
    chk({tag, " R9 excl"}, 64'(both_seen), 0);
    if (cmd[39]) begin
      chk({tag, " R2 we count"}, 64'(we_seen), 1);
      chk({tag, " R2 re none"}, 64'(re_seen), 0);
      chk({tag, " R2 addr/data"}, {25'h0, we_addr, we_data}, {25'h0, cmd[38:32], cmd[31:0]});
      model_reply = cmd[31:0];
    end else begin
      chk({tag, " R3 re count"}, 64'(re_seen), 1);
      chk({tag, " R3 we none"}, 64'(we_seen), 0);
      chk({tag, " R3 addr"}, {57'h0, re_addr}, {57'h0, cmd[38:32]});
      model_reply = bank(cmd[38:32]);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    report();
  end

  initial begin
    logic [63:0] d;
    logic [31:0] wd_before;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 reset idle", {61'h0, miso, reg_we, reg_re}, 0);

    full_frame("rd21a", 8'h5A, {8'h21, 32'h0});              // R6 reply zero after reset
    wd_before = reg_wdata;
    full_frame("rd21b", 8'h3C, {8'h21, 32'hFFFF_FFFF});
    chk("R3 wdata unchanged", {32'h0, reg_wdata}, {32'h0, wd_before});
    full_frame("wr22a", 8'h96, {8'hA2, 32'h00AB_CDEF});      // R4 reply after read, into a write
    full_frame("wr22b", 8'h01, {8'hA2, 32'h0012_3456});      // R5 echo

    // R7: 8-bit frame still yields status, no command
    status = 8'h81;
    xfer(8, 64'hA5, d);
    chk("R7 short8 status", {56'h0, d[7:0]}, {56'h0, 8'h81});
    chk("R7 short8 no strobe", 64'(we_seen + re_seen), 0);

    // R7: 39-bit frame carrying most of a write
    xfer(39, {25'h0, 40'hA2_DEAD_BEEF} >> 1, d);
    chk("R7 short39 no strobe", 64'(we_seen + re_seen), 0);
    chk("R7 short39 wdata", {32'h0, reg_wdata}, {32'h0, 32'h0012_3456});

    full_frame("rd05", 8'h42, {8'h05, 32'h1234_0000});       // R7 reply unchanged

    // R8: 48-bit frame, marker prefix then a read of 0x10
    status = 8'hE7;
    xfer(48, {16'h0, 8'hC3, 8'h10, 32'h0}, d);
    chk("R8 long status", {56'h0, d[47:40]}, {56'h0, 8'hE7});
    chk("R8 long reply", {32'h0, d[39:8]}, {32'h0, model_reply});
    chk("R8 passthrough", {56'h0, d[7:0]}, {56'h0, 8'hC3});
    chk("R8 last40 re", {25'h0, 32'(re_seen), re_addr}, {25'h0, 32'd1, 7'h10});
    chk("R8 last40 we", 64'(we_seen), 0);
    model_reply = bank(7'h10);

    full_frame("rd7f", 8'h18, {8'h7F, 32'h0});
    full_frame("wr00", 8'hFF, {8'h80, 32'hCAFE_F00D});
    full_frame("rd01", 8'h00, {8'h01, 32'h0});
    report();
  end
endmodule